// File: doc/BRIEF.md
# Oscillator Warm-Up Timer

This block measures the settling time of an oscillator that has just been switched on. Software first loads a configuration register and a count register. The configuration register selects a fast or a slow source and a power-of-two prescale. The count register holds the length of the wait, in units of 64 prescaled source periods. Turning an oscillator enable bit from 0 to 1 starts the timer.

The timer counts qualified ticks of the chosen source. At the start it captures the configuration and the count, so software can rewrite both registers while a wait is running without disturbing it. When the terminal tick arrives, the busy flag drops and a sticky done flag rises. In the same cycle a one-cycle interrupt request is raised if the interrupt enable input is high. The done flag stays set until the next start.

Top module: `osc_warmup_timer`

## Requirements
- R1: After reset, `busy`, `done` and `irq` are 0, and both registers hold 0.
- R2: In the cycle after a clock edge that samples a 0-to-1 change on any bit of `osc_en`, `busy` is 1 and `done` is 0.
- R3: An `osc_en` bit that stays at 1 on later edges starts nothing and does not restart a running wait. Only a true 0-to-1 change starts the timer.
- R4: Bit 1 of the configuration register (write select 0) picks the source: 1 counts `slow_tick`, 0 counts `fast_tick`. Ticks of the source that is not picked have no effect.
- R5: Bits [3:2] of the configuration register give the prescale exponent d. A wait with count N ends on the N*64*2^d-th picked tick after the start.
- R6: A count of 0 behaves as a count of 1.
- R7: On the edge that samples the terminal tick, `busy` falls and `done` rises. `irq` is 1 for exactly that one following cycle, and only when `irq_en` was 1 at that edge.
- R8: `done` stays 1 until the next start clears it. `done` and `busy` are never both 1.
- R9: Register writes (write select 1 for the count register) are accepted at any time. A running wait uses the values captured at its start, and the new values apply from the next start. A start and a write in the same cycle capture the old values.
- R10: A new 0-to-1 change while a wait is running restarts the count from zero using the current registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_tick | input | 1 | Qualified tick of the fast source |
| slow_tick | input | 1 | Qualified tick of the slow source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the configuration register, 1 selects the count register |
| wr_data | input | 8 | Write data |
| osc_en | input | 2 | Oscillator enable bits; a rising bit starts the timer |
| irq_en | input | 1 | Interrupt request enable |
| irq | output | 1 | One-cycle completion interrupt request |
| done | output | 1 | Sticky completion flag |
| busy | output | 1 | Wait in progress |

## Verification
Several properties are checked on every cycle. The interrupt is a single-cycle pulse, it only accompanies done, and it only follows an enabled request. Done and busy are exclusive, and done stays set between starts. A start always yields busy in the next cycle. The captured configuration is steady while a wait runs, and the tick counter never passes its target. The bench scenarios cover the things a single cycle cannot show. These are the exact wait length for each prescale and source, the zero-count case, and the absence of restarts when an enable is held high. They also show that a write made during a wait only takes effect at the next start, and that an enable edge arriving mid-wait restarts the count.

// File: rtl/owt_pkg.sv
package owt_pkg;
    typedef enum logic {
        SEL_CFG = 1'b0,
        SEL_CNT = 1'b1
    } reg_sel_e;

    localparam int CFG_SRC_BIT = 1;
    localparam int CFG_DIV_LSB = 2;
endpackage

// File: rtl/owt_regs.sv
module owt_regs #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              src_sel,
    output logic [DIV_W-1:0]  div_sel,
    output logic [DATA_W-1:0] count
);
    import owt_pkg::*;

    typedef struct packed {
        logic              src;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (reg_sel_e'(wr_sel) == SEL_CFG) begin
                r_d.src = wr_data[CFG_SRC_BIT];
                r_d.div = wr_data[CFG_DIV_LSB +: DIV_W];
            end else begin
                r_d.cnt = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign src_sel = r_q.src;
    assign div_sel = r_q.div;
    assign count   = r_q.cnt;
endmodule

// File: rtl/owt_start_det.sv
module owt_start_det #(
    parameter int N_OSC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OSC-1:0] osc_en,
    output logic             start
);
    logic [N_OSC-1:0] prev_d, prev_q;
    logic [N_OSC-1:0] rise;

    always_comb begin
        prev_d = osc_en;
        rise   = osc_en & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign start = |rise;
endmodule

// File: rtl/owt_timer_core.sv
module owt_timer_core #(
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 2,
    parameter int UNIT_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              src_sel,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [DATA_W-1:0] count,
    input  logic              irq_en,
    output logic              busy,
    output logic              done,
    output logic              irq
);
    localparam int MAX_SHIFT = (1 << DIV_W) - 1;
    localparam int CNT_W     = DATA_W + UNIT_LOG2 + MAX_SHIFT;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              irq;
        logic              src;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] n;
        logic [CNT_W-1:0]  cnt;
    } core_t;

    core_t s_d, s_q;
    logic              tick;
    logic [DATA_W-1:0] n_eff;
    logic [CNT_W-1:0]  target;
    logic [CNT_W-1:0]  cnt_inc;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        tick    = s_q.src ? slow_tick : fast_tick;
        n_eff   = (s_q.n == '0) ? DATA_W'(1) : s_q.n;
        target  = CNT_W'(n_eff) << (UNIT_LOG2 + int'(s_q.div));
        cnt_inc = s_q.cnt + CNT_W'(1);
        if (start) begin
            s_d.busy = 1'b1;
            s_d.done = 1'b0;
            s_d.src  = src_sel;
            s_d.div  = div_sel;
            s_d.n    = count;
            s_d.cnt  = '0;
        end else if (s_q.busy && tick) begin
            if (cnt_inc == target) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.irq  = irq_en;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign irq  = s_q.irq;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |=> !s_q.irq); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.irq) |-> $past(irq_en) && s_q.done); // R7
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.done && s_q.busy)); // R8
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done && !start |=> s_q.done); // R8
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && !start |=> $stable(s_q.src) && $stable(s_q.div) && $stable(s_q.n)); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> s_q.cnt < target); // R5
endmodule

// File: rtl/osc_warmup_timer.sv
module osc_warmup_timer #(
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 2,
    parameter int UNIT_LOG2 = 6,
    parameter int N_OSC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_OSC-1:0]  osc_en,
    input  logic              irq_en,
    output logic              irq,
    output logic              done,
    output logic              busy
);
    logic              start;
    logic              src_sel;
    logic [DIV_W-1:0]  div_sel;
    logic [DATA_W-1:0] count;

    owt_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .src_sel(src_sel), .div_sel(div_sel), .count(count)
    );

    owt_start_det #(.N_OSC(N_OSC)) u_det (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .start(start)
    );

    owt_timer_core #(.DATA_W(DATA_W), .DIV_W(DIV_W), .UNIT_LOG2(UNIT_LOG2)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .fast_tick(fast_tick),
        .slow_tick(slow_tick), .src_sel(src_sel), .div_sel(div_sel),
        .count(count), .irq_en(irq_en), .busy(busy), .done(done), .irq(irq)
    );

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && !done); // R2
endmodule

// File: tb/osc_warmup_timer_tb.sv
module osc_warmup_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_tick = 1'b0, slow_tick = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] osc_en = 2'b00;
    logic       irq_en = 1'b0;
    logic       irq, done, busy;

    int checks = 0, failures = 0;
    int tick_mode = 0, phase = 0, irq_count = 0, wd = 0;

    // behavioural reference
    int m_rem = 0, m_src = 0;
    bit m_busy = 0, m_done = 0, m_irq = 0;
    bit [1:0] m_prev = 0;
    bit [7:0] m_cfg = 0, m_cnt = 0;

    always #2.5 clk = ~clk;

    osc_warmup_timer u_dut (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .osc_en(osc_en),
        .irq_en(irq_en), .irq(irq), .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_irq = 0; m_prev = 0;
            m_cfg = 0; m_cnt = 0; m_rem = 0; m_src = 0;
        end else begin
            bit rise;
            rise   = |(osc_en & ~m_prev);
            m_prev = osc_en;
            m_irq  = 0;
            if (rise) begin
                m_busy = 1; m_done = 0;
                m_src  = m_cfg[1];
                m_rem  = ((m_cnt == 0) ? 1 : int'(m_cnt)) * 64 * (1 << m_cfg[3:2]);
            end else if (m_busy && (m_src ? slow_tick : fast_tick)) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_busy = 0; m_done = 1; m_irq = irq_en;
                end
            end
            if (wr_en) begin
                if (wr_sel) m_cnt = wr_data;
                else        m_cfg = wr_data;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == m_busy, "R2 busy vs model", busy, m_busy);
            check(done == m_done, "R8 done vs model", done, m_done);
            check(irq == m_irq, "R7 irq vs model", irq, m_irq);
            if (irq) irq_count++;
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        phase++;
        if (tick_mode == 0) begin
            fast_tick = 1'b1; slow_tick = 1'b1;
        end else if (tick_mode == 1) begin
            fast_tick = 1'b1; slow_tick = (phase % 3 == 0);
        end else begin
            fast_tick = 1'b1; slow_tick = 1'b0;
        end
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    // raise one enable bit, return cycles from start edge to done edge
    task automatic run_to_done(input int b, output int lat);
        int cyc = 0;
        osc_en[b] = 1'b1;
        do begin
            step(); cyc++;
        end while (!done && cyc < 30000);
        lat = cyc - 1;
    endtask

    initial begin
        int lat;
        step(); step();
        check(busy == 0 && done == 0 && irq == 0, "R1 reset outputs", {busy, done, irq}, 0);
        rst_n = 1'b1;
        step();
        check(busy == 0 && done == 0, "R1 idle after reset", {busy, done}, 0);

        // slow source, no division, count 1
        irq_en = 1'b1;
        wr(0, 8'h02); wr(1, 8'h01);
        irq_count = 0;
        run_to_done(1, lat);
        check(lat == 64, "R5 slow div0 n1 latency", lat, 64);
        step();
        check(irq_count == 1, "R7 one irq pulse", irq_count, 1);
        // held enable: no restart
        repeat (20) step();
        check(busy == 0 && done == 1, "R3 held enable no restart", busy, 0);
        osc_en = 2'b00; step();

        // fast source, div 3
        wr(0, 8'h0C); wr(1, 8'h01);
        run_to_done(0, lat);
        check(lat == 512, "R5 fast div3 latency", lat, 512);
        osc_en = 2'b00; step();

        // count 0 acts as 1, div 1
        wr(0, 8'h04); wr(1, 8'h00);
        run_to_done(0, lat);
        check(lat == 128, "R6 zero count latency", lat, 128);
        osc_en = 2'b00; step();

        // unselected source ignored
        tick_mode = 2;
        wr(0, 8'h02); wr(1, 8'h01);
        osc_en[1] = 1'b1;
        repeat (100) step();
        check(busy == 1 && done == 0, "R4 fast ticks ignored on slow", busy, 1);
        tick_mode = 1;
        irq_en = 1'b0; irq_count = 0;
        repeat (300) step();
        check(done == 1 && irq_count == 0, "R7 gated irq stays low", irq_count, 0);
        osc_en = 2'b00; irq_en = 1'b1; step();

        // writes during a wait apply next start
        tick_mode = 0;
        wr(0, 8'h02); wr(1, 8'h01);
        osc_en[1] = 1'b1;
        step();
        wr(1, 8'h05); wr(0, 8'h0C);
        begin
            int cyc = 3;
            while (!done && cyc < 1000) begin step(); cyc++; end
            check(cyc - 1 == 64, "R9 running wait unaffected", cyc - 1, 64);
        end
        osc_en = 2'b00; step();
        run_to_done(0, lat);
        check(lat == 2560, "R9 new values at next start", lat, 2560);
        osc_en = 2'b00; step();

        // restart mid-wait, with enable held on the other bit
        wr(0, 8'h02); wr(1, 8'h01);
        osc_en[1] = 1'b1;
        repeat (30) step();
        run_to_done(0, lat);
        check(lat == 64, "R10 restart from zero", lat, 64);
        check(busy == 0, "R3 held bits no restart", busy, 0);

        // start and write in the same cycle captures old values
        osc_en = 2'b00; step();
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h03; osc_en[1] = 1'b1;
        step();
        wr_en = 1'b0;
        begin
            int cyc = 1;
            while (!done && cyc < 1000) begin step(); cyc++; end
            check(cyc - 1 == 64, "R9 same-cycle write uses old", cyc - 1, 64);
        end
        repeat (3) step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule